// File: doc/BRIEF.md
# Processor Speed Strap Controller

This block presents the processor's core-frequency selection on four sideband lines while the platform comes out of reset, and afterwards gives those lines back to their everyday sources. Power-good starts the sequence. At that edge the block captures a 4-bit strap register and the 2-bit exit-state code. For every exit code except light sleep it then releases the platform reset and drives the captured pattern. It keeps driving the pattern while the host controller holds the CPU in reset and for a fixed hold window afterwards. Then a registered select moves each line's 2:1 multiplexer over to the normal signal.

The strap register sits in the always-powered domain and has its own reset, which loads all ones. A platform reset does not change it. A write port loads it. Two conditions force it to all ones: a pin-strap input, and a boot watchdog that expires when boot-done is not seen in time after the CPU reset is released.

The sequencer has five named states. `ST_OFF` asserts the platform reset and drives all lines high. `ST_WAIT_CPU` drives the pattern until the CPU reset is released. `ST_HOLD` keeps the pattern for `HOLD_CYC` cycles. `ST_BOOT` uses the normal sources while the watchdog runs. `ST_RUN` is the normal operating state.

Its transitions are:
- OFF→RUN when power-good rises with the light-sleep code.
- OFF→WAIT_CPU when power-good rises with any other code.
- WAIT_CPU→HOLD when the CPU reset is released.
- HOLD→BOOT when the hold window expires.
- BOOT→RUN when boot-done is seen or the watchdog expires.
- Any state→OFF when power-good drops.

Top module: `speed_strap_ctrl`

## Requirements
- R1: While `plat_rst_n` is low, `side_out` is 4'b1111.
- R2: The pattern driven is the register value captured in the cycle power-good is first seen high in `ST_OFF`. Writes made after that do not change the pattern being driven.
- R3: During strap drive, `side_out[3]` (NMI line), `[2]` (INTR), `[1]` (IGNNE line) and `[0]` (A20 mask line) each equal the matching captured strap bit, independent of `norm_side`.
- R4: With `exit_state` 2'b00 (light sleep), one clock after power-good is seen `plat_rst_n` is high and `side_out` follows `norm_side`. No strap pattern is driven.
- R5: With `exit_state` 2'b01, 2'b10 or 2'b11, one clock after power-good is seen `plat_rst_n` goes high and `side_out` shows the pattern while `host_cpu_rst_n` stays low.
- R6: The pattern stays for `HOLD_CYC` = ceil(`HOLD_PS`/`CLK_PERIOD_PS`) clocks after `host_cpu_rst_n` is first sampled high. After that, `side_out` follows `norm_side`.
- R7: While `strap_force` is high the strap register loads 4'b1111, with priority over a write.
- R8: If `boot_done` is low for `WDOG_CYC` clocks after the switch to normal sources, the register becomes 4'b1111. If `boot_done` arrives in time, the register is kept.
- R9: `cfg_we` loads `cfg_wdata` into the register. The value survives platform resets. `aon_rst_n` sets it to 4'b1111.
- R10: Power-good low in any state reasserts `plat_rst_n` low on the next clock, with all lines high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the sequencer |
| aon_rst_n | input | 1 | Active-low reset of the always-powered strap register |
| pwr_good | input | 1 | Power-good |
| exit_state | input | 2 | Sleep state being left: 00 light sleep, 01/10/11 deeper states or off |
| host_cpu_rst_n | input | 1 | CPU reset from the host controller, active low |
| strap_force | input | 1 | Pin-strap override forcing all ones |
| boot_done | input | 1 | Processor reports a successful boot |
| cfg_we | input | 1 | Strap register write enable |
| cfg_wdata | input | 4 | Strap register write data |
| norm_side | input | 4 | Normal sources: [3] NMI, [2] INTR, [1] IGNNE, [0] A20 mask |
| plat_rst_n | output | 1 | Platform reset, active low |
| side_out | output | 4 | Shared sideband lines, same bit order as `norm_side` |

## Verification
The strap patterns 0101, 1010 and 0011 are each driven with `norm_side` set to their complement, so a swapped bit or a line that picks the wrong mux input shows a visible mismatch. All three non-sleep exit codes are run, against a light-sleep exit where the normal sources change while they are watched, which separates "no strap" from "strap then switch". The hold window is sampled on its last strap cycle and on its first normal cycle. A write made during the wait stage, a pin force, a missed boot and a timely boot are each read back on the following power-up pattern.

// File: rtl/strap_pkg.sv
package strap_pkg;

    typedef enum logic [1:0] {
        EXIT_LIGHT = 2'b00,
        EXIT_SUSP  = 2'b01,
        EXIT_DISK  = 2'b10,
        EXIT_MOFF  = 2'b11
    } exit_code_e;

    typedef enum logic [1:0] {
        SEL_HIGH  = 2'b00,
        SEL_STRAP = 2'b01,
        SEL_NORM  = 2'b10
    } line_sel_e;

    typedef enum logic [2:0] {
        ST_OFF      = 3'd0,
        ST_WAIT_CPU = 3'd1,
        ST_HOLD     = 3'd2,
        ST_BOOT     = 3'd3,
        ST_RUN      = 3'd4
    } seq_state_e;

endpackage

// File: rtl/strap_reg.sv
module strap_reg #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             aon_rst_n,
    input  logic             pin_force,
    input  logic             fail_force,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] value_q
);
    localparam logic [WIDTH-1:0] ALL_ONES = '1;

    always_ff @(posedge clk or negedge aon_rst_n) begin
        if (!aon_rst_n)
            value_q <= ALL_ONES;
        else if (pin_force || fail_force)
            value_q <= ALL_ONES;
        else if (wr_en)
            value_q <= wr_data;
    end

    // R7: pin override always wins
    p_force_ones_r7: assert property (@(posedge clk) disable iff (!aon_rst_n)
        pin_force |=> value_q == ALL_ONES);

    // R8: failed boot falls back to all ones
    p_boot_fail_r8: assert property (@(posedge clk) disable iff (!aon_rst_n)
        fail_force |=> value_q == ALL_ONES);

endmodule

// File: rtl/strap_cycle_timer.sv
module strap_cycle_timer #(
    parameter int LIMIT = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign expired = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run)
            cnt_q <= '0;
        else if (!expired)
            cnt_q <= cnt_q + 1'b1;
    end

    // R6: the window counter never passes its terminal count
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/strap_seq_fsm.sv
module strap_seq_fsm
    import strap_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_good,
    input  logic [1:0]       exit_state,
    input  logic             host_cpu_rst_n,
    input  logic             boot_done,
    input  logic [WIDTH-1:0] strap_q,
    input  logic             hold_done,
    input  logic             wdog_done,
    output logic             hold_run,
    output logic             wdog_run,
    output logic             boot_fail,
    output logic [WIDTH-1:0] pat_q,
    output line_sel_e        sel_q,
    output logic             plat_rst_n
);
    seq_state_e state_q, state_d;
    line_sel_e  sel_d;
    logic       capture;

    // next-state logic
    always_comb begin
        state_d   = state_q;
        boot_fail = 1'b0;
        capture   = 1'b0;
        if (!pwr_good) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    capture = 1'b1;
                    if (exit_code_e'(exit_state) == EXIT_LIGHT)
                        state_d = ST_RUN;
                    else
                        state_d = ST_WAIT_CPU;
                end
                ST_WAIT_CPU: if (host_cpu_rst_n) state_d = ST_HOLD;
                ST_HOLD:     if (hold_done) state_d = ST_BOOT;
                ST_BOOT: begin
                    if (boot_done) begin
                        state_d = ST_RUN;
                    end else if (wdog_done) begin
                        state_d   = ST_RUN;
                        boot_fail = 1'b1;
                    end
                end
                ST_RUN:      state_d = ST_RUN;
                default:     state_d = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            pat_q   <= '1;
        end else begin
            state_q <= state_d;
            if (capture)
                pat_q <= strap_q;
        end
    end

    // output decode from the next state, registered for glitch-free select
    always_comb begin
        unique case (state_d)
            ST_OFF:                sel_d = SEL_HIGH;
            ST_WAIT_CPU, ST_HOLD:  sel_d = SEL_STRAP;
            ST_BOOT, ST_RUN:       sel_d = SEL_NORM;
            default:               sel_d = SEL_HIGH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q      <= SEL_HIGH;
            plat_rst_n <= 1'b0;
        end else begin
            sel_q      <= sel_d;
            plat_rst_n <= (state_d != ST_OFF);
        end
    end

    assign hold_run = (state_q == ST_HOLD);
    assign wdog_run = (state_q == ST_BOOT);

    // R4: light-sleep exit goes straight to the normal sources
    p_light_no_strap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && pwr_good && exit_state == 2'b00)
        |=> (sel_q == SEL_NORM && plat_rst_n));

    // R5: platform reset is released only after power-good was present
    p_release_after_pg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(plat_rst_n) |-> $past(pwr_good));

    // R6: pattern stays selected inside the hold window
    p_hold_strap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !hold_done && pwr_good) |=> sel_q == SEL_STRAP);

    // R10: losing power-good reasserts the platform reset
    p_pg_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> !plat_rst_n);

endmodule

// File: rtl/strap_side_mux.sv
module strap_side_mux
    import strap_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  line_sel_e        sel,
    input  logic [WIDTH-1:0] strap_bits,
    input  logic [WIDTH-1:0] norm_bits,
    output logic [WIDTH-1:0] line_out
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        always_comb begin
            case (sel)
                SEL_STRAP: line_out[i] = strap_bits[i];
                SEL_NORM:  line_out[i] = norm_bits[i];
                default:   line_out[i] = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/speed_strap_ctrl.sv
module speed_strap_ctrl
    import strap_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 10000,
    parameter int HOLD_PS       = 120000,
    parameter int WDOG_CYC      = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       aon_rst_n,
    input  logic       pwr_good,
    input  logic [1:0] exit_state,
    input  logic       host_cpu_rst_n,
    input  logic       strap_force,
    input  logic       boot_done,
    input  logic       cfg_we,
    input  logic [3:0] cfg_wdata,
    input  logic [3:0] norm_side,
    output logic       plat_rst_n,
    output logic [3:0] side_out
);
    localparam int LINES    = 4;
    localparam int HOLD_CYC = (HOLD_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;

    logic [LINES-1:0] strap_q, pat_q;
    logic             hold_run, hold_done, wdog_run, wdog_done, boot_fail;
    line_sel_e        sel_q;

    strap_reg #(.WIDTH(LINES)) u_reg (
        .clk        (clk),
        .aon_rst_n  (aon_rst_n),
        .pin_force  (strap_force),
        .fail_force (boot_fail),
        .wr_en      (cfg_we),
        .wr_data    (cfg_wdata),
        .value_q    (strap_q)
    );

    strap_cycle_timer #(.LIMIT(HOLD_CYC)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (hold_run),
        .expired (hold_done)
    );

    strap_cycle_timer #(.LIMIT(WDOG_CYC)) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (wdog_run),
        .expired (wdog_done)
    );

    strap_seq_fsm #(.WIDTH(LINES)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .pwr_good       (pwr_good),
        .exit_state     (exit_state),
        .host_cpu_rst_n (host_cpu_rst_n),
        .boot_done      (boot_done),
        .strap_q        (strap_q),
        .hold_done      (hold_done),
        .wdog_done      (wdog_done),
        .hold_run       (hold_run),
        .wdog_run       (wdog_run),
        .boot_fail      (boot_fail),
        .pat_q          (pat_q),
        .sel_q          (sel_q),
        .plat_rst_n     (plat_rst_n)
    );

    strap_side_mux #(.WIDTH(LINES)) u_mux (
        .sel        (sel_q),
        .strap_bits (pat_q),
        .norm_bits  (norm_side),
        .line_out   (side_out)
    );

    // R1: lines sit high whenever the platform is held in reset
    p_high_in_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !plat_rst_n |-> side_out == 4'hF);

endmodule

// File: tb/speed_strap_ctrl_test.sv
module speed_strap_ctrl_test;

    localparam int HOLD = (120000 + 9999) / 10000;
    localparam int WDOG = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0, aon_rst_n = 1'b0;
    logic       pwr_good = 1'b0;
    logic [1:0] exit_state = 2'b01;
    logic       host_cpu_rst_n = 1'b0;
    logic       strap_force = 1'b0;
    logic       boot_done = 1'b1;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_wdata = 4'h0;
    logic [3:0] norm_side = 4'h0;
    logic       plat_rst_n;
    logic [3:0] side_out;

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    speed_strap_ctrl #(.CLK_PERIOD_PS(10000), .HOLD_PS(120000), .WDOG_CYC(WDOG)) uut (
        .clk(clk), .rst_n(rst_n), .aon_rst_n(aon_rst_n), .pwr_good(pwr_good),
        .exit_state(exit_state), .host_cpu_rst_n(host_cpu_rst_n),
        .strap_force(strap_force), .boot_done(boot_done), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .norm_side(norm_side),
        .plat_rst_n(plat_rst_n), .side_out(side_out)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic write_reg(input logic [3:0] v);
        cfg_we = 1'b1; cfg_wdata = v; step(); cfg_we = 1'b0;
    endtask

    // drop power, then raise it with the given exit code
    task automatic power_up(input logic [1:0] code);
        pwr_good = 1'b0; host_cpu_rst_n = 1'b0; step(2);
        exit_state = code; pwr_good = 1'b1; step();
    endtask

    // release CPU reset and let the hold window run out
    task automatic finish_boot();
        host_cpu_rst_n = 1'b1; step(HOLD + 2);
    endtask

    task automatic t_reset();
        check("R1 reset plat_rst_n", {7'd0, plat_rst_n}, 8'h00);
        check("R1 reset lines high", {4'd0, side_out}, 8'h0F);
        rst_n = 1'b1; aon_rst_n = 1'b1; step(2);
        check("R1 off lines high", {3'd0, plat_rst_n, side_out}, 8'h0F);
        // R9: always-on reset value is all ones
        power_up(2'b01);
        check("R9 aon reset value", {4'd0, side_out}, 8'h0F);
        finish_boot();
    endtask

    task automatic t_pattern(input logic [3:0] pat, input logic [1:0] code);
        write_reg(pat);
        norm_side = ~pat;
        power_up(code);
        check("R5 reset released", {7'd0, plat_rst_n}, 8'h01);
        check("R3 bit mapping", {4'd0, side_out}, {4'd0, pat});
        step(5);
        check("R5 held during cpu reset", {4'd0, side_out}, {4'd0, pat});
        host_cpu_rst_n = 1'b1;
        step(HOLD);
        check("R6 last strap cycle", {4'd0, side_out}, {4'd0, pat});
        step();
        check("R6 switch to normal", {4'd0, side_out}, {4'd0, ~pat});
        step();
    endtask

    task automatic t_light();
        write_reg(4'h9);
        norm_side = 4'h6;
        power_up(2'b00);
        check("R4 reset released", {7'd0, plat_rst_n}, 8'h01);
        check("R4 normal at once", {4'd0, side_out}, 8'h06);
        norm_side = 4'h3; step();
        check("R4 follows normal", {4'd0, side_out}, 8'h03);
    endtask

    task automatic t_capture();
        write_reg(4'h5);
        norm_side = 4'h0;
        power_up(2'b10);
        write_reg(4'hA);
        check("R2 captured pattern kept", {4'd0, side_out}, 8'h05);
        finish_boot();
        power_up(2'b10);
        check("R9 write survives reset", {4'd0, side_out}, 8'h0A);
        finish_boot();
    endtask

    task automatic t_force();
        write_reg(4'h2);
        strap_force = 1'b1; cfg_we = 1'b1; cfg_wdata = 4'h4; step();
        cfg_we = 1'b0; strap_force = 1'b0;
        power_up(2'b11);
        check("R7 pin force ones", {4'd0, side_out}, 8'h0F);
        finish_boot();
    endtask

    task automatic t_boot(input bit ok);
        write_reg(4'h6);
        power_up(2'b01);
        boot_done = ok;
        finish_boot();
        step(WDOG + 10);
        boot_done = 1'b1;
        power_up(2'b01);
        check(ok ? "R8 timely boot keeps value" : "R8 failed boot forces ones",
              {4'd0, side_out}, ok ? 8'h06 : 8'h0F);
        finish_boot();
    endtask

    task automatic t_pg_drop();
        norm_side = 4'h0;
        check("R10 running", {3'd0, plat_rst_n, side_out}, 8'h10);
        pwr_good = 1'b0; step();
        check("R10 drop reasserts reset", {3'd0, plat_rst_n, side_out}, 8'h0F);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_pattern(4'b0101, 2'b01);
        t_pattern(4'b1010, 2'b10);
        t_pattern(4'b0011, 2'b11);
        t_light();
        t_capture();
        t_force();
        t_boot(1'b0);
        t_boot(1'b1);
        t_pg_drop();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule